// File: doc/BRIEF.md
# Interrupt Request Priority Controller

This block tracks interrupt vectors on their way to a processor. It keeps three 256-bit sets indexed by vector number: vectors that are requested, vectors that are in service, and the trigger kind each vector last arrived with. An arrival names a vector and says whether it is level or edge triggered. The block works out a processor priority from its task-priority value and the highest vector in service. It raises its interrupt line when the best requested vector belongs to a higher 16-vector class than that priority.

The processor takes an interrupt with a one-cycle acknowledge strobe. The vector appears on the acknowledge output during that cycle, and the bit moves from the requested set to the in-service set at the closing edge. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level triggered, the block may announce it on a broadcast output so that the interrupt sources can re-sample their lines.

A small register port writes the task priority and the spurious-vector register, and reads back every vector set one 32-bit word at a time. Reads are combinational.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When `arr_valid` is high at a clock edge, the IRR bit of `arr_vector` is set from that edge. The TMR bit of that vector becomes `arr_level` (1 means level, 0 means edge).
- R2: `arr_new` is high in an arrival cycle exactly when the IRR bit of the arriving vector was clear before that edge.
- R3: The processor priority (PPR, read at address 0x02) takes ISRV as the highest in-service vector, or 0 when none is in service. PPR equals TPR when TPR[7:4] >= ISRV[7:4]; otherwise it equals {ISRV[7:4], 4'h0}.
- R4: A request is pending when IRR is non-empty and either PPR is zero or the upper nibble of the highest IRR vector is strictly greater than PPR[7:4]. `int_out` reflects the pending state in the same cycle as any change of state.
- R5: A `cpu_tpr_we` strobe stores {cpu_tpr_nib, 4'h0} into TPR. A register write to address 0x00 stores `reg_wdata[7:0]` into TPR. TPR reads back at 0x00.
- R6: While a request is pending and software enable is set, `ack_vector` shows the highest IRR vector. An `ack` strobe then clears that IRR bit and sets its ISR bit.
- R7: When no request is pending, or software enable is clear, `ack_vector` shows SVR[7:0]. An `ack` strobe then leaves every set unchanged.
- R8: An `eoi` strobe clears the highest set ISR bit. With ISR empty it changes nothing.
- R9: `eoi_bcast` is high in an `eoi` cycle exactly when an ISR bit is retired, its TMR bit is set and SVR bit 12 is clear. `eoi_bcast_vector` then carries that vector.
- R10: SVR bit 8 is the software enable; while it is clear, `int_out` stays low. A write to address 0x01 keeps only bits 12 and 8:0 and clears the rest. SVR resets to 0x0FF.
- R11: A synchronous active-high `rst` clears IRR, ISR, TMR and TPR.
- R12: Reads at 0x08+w, 0x10+w and 0x18+w return word w of ISR, TMR and IRR respectively, where bit b is vector 32w+b. Other unmapped addresses read 0, and writes to the window addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | Interrupt arrival strobe |
| arr_vector | input | 8 | Arriving vector number |
| arr_level | input | 1 | Arrival trigger kind, 1 = level |
| arr_new | output | 1 | Arrival found its IRR bit clear |
| cpu_tpr_we | input | 1 | Processor-path task-priority write |
| cpu_tpr_nib | input | 4 | Priority class for the processor-path write |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vector | output | 8 | Vector returned to the acknowledge |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_bcast | output | 1 | Level-triggered vector retired, broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector announced with the broadcast |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
A bad bit in the requested or in-service set shows at the ports in the same cycle. It appears on `int_out`, on the PPR read and on the vector that an acknowledge would return. A wrong trigger bit stays hidden until that vector is retired, and it then appears as a missing or extra broadcast pulse. The directed sequences therefore acknowledge and retire every vector they raise, and they read each window word right after the edge that changes it. The same-cycle order of arrival over acknowledge, and of acknowledge over retirement, is visible one edge later in the window reads.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int VEC_W     = 8;
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int WSEL_W    = $clog2(NUM_WORDS);
    localparam int REG_AW    = WSEL_W + 2;
    localparam int DATA_W    = 32;
    localparam int CLASS_W   = 4;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
    } scan_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
        logic level;
    } arrival_t;

    typedef enum logic [1:0] {
        RGN_SCALAR = 2'd0,
        RGN_ISR    = 2'd1,
        RGN_TMR    = 2'd2,
        RGN_IRR    = 2'd3
    } region_e;

    localparam logic [WSEL_W-1:0] SC_TPR = WSEL_W'(0);
    localparam logic [WSEL_W-1:0] SC_SVR = WSEL_W'(1);
    localparam logic [WSEL_W-1:0] SC_PPR = WSEL_W'(2);

    localparam int SVR_EN_BIT  = 8;
    localparam int SVR_DIR_BIT = 12;
    localparam logic [DATA_W-1:0] SVR_KEEP  = 32'h0000_11FF;
    localparam logic [DATA_W-1:0] SVR_RESET = 32'h0000_00FF;

    function automatic logic [CLASS_W-1:0] prio_class(input vec_t v);
        return v[VEC_W-1 -: CLASS_W];
    endfunction

    function automatic vec_t class_floor(input vec_t v);
        return {prio_class(v), {(VEC_W-CLASS_W){1'b0}}};
    endfunction

endpackage

// File: rtl/vec_scan.sv
module vec_scan
    import irq_prio_pkg::*;
#(
    parameter int NV = NUM_VEC,
    parameter int WW = WORD_W
) (
    input  logic [NV-1:0] bits,
    output scan_t         res
);
    localparam int NW = NV / WW;
    localparam int BW = $clog2(WW);

    logic          word_any [NW];
    logic [BW-1:0] word_top [NW];

    function automatic logic [BW-1:0] top_in_word(input logic [WW-1:0] w);
        logic [BW-1:0] idx;
        idx = '0;
        for (int b = 0; b < WW; b++) begin
            if (w[b]) idx = BW'(b);
        end
        return idx;
    endfunction

    for (genvar g = 0; g < NW; g++) begin : g_word
        assign word_any[g] = |bits[g*WW +: WW];
        assign word_top[g] = top_in_word(bits[g*WW +: WW]);
    end

    always_comb begin
        res = '0;
        for (int w = 0; w < NW; w++) begin
            if (word_any[w]) begin
                res.valid = 1'b1;
                res.vec   = VEC_W'(w * WW) + VEC_W'(word_top[w]);
            end
        end
    end

endmodule

// File: rtl/prio_eval.sv
module prio_eval
    import irq_prio_pkg::*;
(
    input  vec_t  tpr,
    input  scan_t isr_top,
    input  scan_t irr_top,
    output vec_t  ppr,
    output logic  pending
);
    vec_t isrv;

    always_comb begin
        isrv = isr_top.valid ? isr_top.vec : '0;
        if (prio_class(tpr) >= prio_class(isrv)) ppr = tpr;
        else                                      ppr = class_floor(isrv);
    end

    always_comb begin
        pending = 1'b0;
        if (irr_top.valid) begin
            if (ppr == '0) pending = 1'b1;
            else           pending = prio_class(irr_top.vec) > prio_class(ppr);
        end
    end

endmodule

// File: rtl/vec_sets.sv
module vec_sets
    import irq_prio_pkg::*;
#(
    parameter int NV = NUM_VEC
) (
    input  logic          clk,
    input  logic          rst,
    input  arrival_t      arr,
    input  logic          ack_take,
    input  vec_t          ack_vec,
    input  logic          eoi_take,
    input  vec_t          eoi_vec,
    output logic [NV-1:0] irr,
    output logic [NV-1:0] isr,
    output logic [NV-1:0] tmr,
    output logic          arr_new
);

    assign arr_new = arr.valid & ~irr[arr.vec];

    always_ff @(posedge clk) begin
        if (rst) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            // Retirement first, then acknowledge, then arrival: later wins.
            if (eoi_take) isr[eoi_vec] <= 1'b0;
            if (ack_take) begin
                irr[ack_vec] <= 1'b0;
                isr[ack_vec] <= 1'b1;
            end
            if (arr.valid) begin
                irr[arr.vec] <= 1'b1;
                tmr[arr.vec] <= arr.level;
            end
        end
    end

    // R1
    irr_set_chk: assert property (@(posedge clk) disable iff (rst)
        arr.valid |=> irr[$past(arr.vec)]);

    // R1
    tmr_kind_chk: assert property (@(posedge clk) disable iff (rst)
        arr.valid |=> (tmr[$past(arr.vec)] == $past(arr.level)));

    // R6
    ack_move_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !(arr.valid && arr.vec == ack_vec))
        |=> (!irr[$past(ack_vec)] && isr[$past(ack_vec)]));

    // R8
    eoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_take && !(ack_take && ack_vec == eoi_vec)) |=> !isr[$past(eoi_vec)]);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_valid,
    input  logic [VEC_W-1:0]  arr_vector,
    input  logic              arr_level,
    output logic              arr_new,
    input  logic              cpu_tpr_we,
    input  logic [CLASS_W-1:0] cpu_tpr_nib,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ack,
    output logic [VEC_W-1:0]  ack_vector,
    input  logic              eoi,
    output logic              eoi_bcast,
    output logic [VEC_W-1:0]  eoi_bcast_vector,
    output logic              int_out
);

    logic [NUM_VEC-1:0] irr, isr, tmr;
    scan_t              irr_top, isr_top;
    vec_t               tpr, ppr;
    logic [DATA_W-1:0]  svr;
    logic               pending, sw_en, ack_take, eoi_take;
    arrival_t           arr;

    region_e            rgn;
    logic [WSEL_W-1:0]  sub;

    assign arr   = '{valid: arr_valid, vec: arr_vector, level: arr_level};
    assign sw_en = svr[SVR_EN_BIT];
    assign rgn   = region_e'(reg_addr[REG_AW-1 -: 2]);
    assign sub   = reg_addr[WSEL_W-1:0];

    vec_scan #(.NV(NUM_VEC), .WW(WORD_W)) u_irr_scan (.bits(irr), .res(irr_top));
    vec_scan #(.NV(NUM_VEC), .WW(WORD_W)) u_isr_scan (.bits(isr), .res(isr_top));

    prio_eval u_prio (
        .tpr     (tpr),
        .isr_top (isr_top),
        .irr_top (irr_top),
        .ppr     (ppr),
        .pending (pending)
    );

    assign ack_take = ack & sw_en & pending;
    assign eoi_take = eoi & isr_top.valid;

    vec_sets #(.NV(NUM_VEC)) u_sets (
        .clk      (clk),
        .rst      (rst),
        .arr      (arr),
        .ack_take (ack_take),
        .ack_vec  (irr_top.vec),
        .eoi_take (eoi_take),
        .eoi_vec  (isr_top.vec),
        .irr      (irr),
        .isr      (isr),
        .tmr      (tmr),
        .arr_new  (arr_new)
    );

    assign int_out          = sw_en & pending;
    assign ack_vector       = (sw_en && pending) ? irr_top.vec : svr[VEC_W-1:0];
    assign eoi_bcast        = eoi_take & tmr[isr_top.vec] & ~svr[SVR_DIR_BIT];
    assign eoi_bcast_vector = isr_top.vec;

    // Scalar registers: task priority and spurious vector.
    always_ff @(posedge clk) begin
        if (rst) begin
            tpr <= '0;
            svr <= SVR_RESET;
        end else begin
            if (reg_we && rgn == RGN_SCALAR && sub == SC_TPR)
                tpr <= reg_wdata[VEC_W-1:0];
            else if (cpu_tpr_we)
                tpr <= {cpu_tpr_nib, {(VEC_W-CLASS_W){1'b0}}};
            if (reg_we && rgn == RGN_SCALAR && sub == SC_SVR)
                svr <= reg_wdata & SVR_KEEP;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (rgn)
            RGN_SCALAR: begin
                if (sub == SC_TPR)      reg_rdata = DATA_W'(tpr);
                else if (sub == SC_SVR) reg_rdata = svr;
                else if (sub == SC_PPR) reg_rdata = DATA_W'(ppr);
            end
            RGN_ISR: reg_rdata = isr[sub*WORD_W +: WORD_W];
            RGN_TMR: reg_rdata = tmr[sub*WORD_W +: WORD_W];
            RGN_IRR: reg_rdata = irr[sub*WORD_W +: WORD_W];
            default: reg_rdata = '0;
        endcase
    end

    // R9
    bcast_src_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast |-> (eoi && !svr[SVR_DIR_BIT]));

    // R7
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out && !arr_valid) |=> $stable(irr));

    // R4
    int_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        int_out |-> irr_top.valid);

    // R10
    svr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (svr & ~SVR_KEEP) == '0);

endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arr_valid = 1'b0;
    logic [7:0]  arr_vector = '0;
    logic        arr_level = 1'b0;
    logic        arr_new;
    logic        cpu_tpr_we = 1'b0;
    logic [3:0]  cpu_tpr_nib = '0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ack = 1'b0;
    logic [7:0]  ack_vector;
    logic        eoi = 1'b0;
    logic        eoi_bcast;
    logic [7:0]  eoi_bcast_vector;
    logic        int_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    irq_prio_ctrl dut (.*);

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic arrive(input logic [7:0] v, input logic lvl, input logic exp_new);
        arr_valid = 1'b1; arr_vector = v; arr_level = lvl;
        #1;
        chk("R2 arr_new", arr_new, exp_new);
        tick();
        arr_valid = 1'b0;
    endtask

    task automatic do_ack(input string req, input logic [7:0] exp_vec);
        ack = 1'b1;
        #1;
        chk(req, ack_vector, exp_vec);
        tick();
        ack = 1'b0;
    endtask

    task automatic do_eoi(input logic exp_b, input logic [7:0] exp_v);
        eoi = 1'b1;
        #1;
        chk("R9 eoi_bcast", eoi_bcast, exp_b);
        if (exp_b) chk("R9 eoi_bcast_vector", eoi_bcast_vector, exp_v);
        tick();
        eoi = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 int_out", int_out, 0);
        chk_rd("R11 tpr", 5'h00, 0);
        chk_rd("R10 svr reset", 5'h01, 32'h0FF);
        chk_rd("R3 ppr", 5'h02, 0);
        chk_rd("R11 irr w7", 5'h1F, 0);
        chk_rd("R11 isr w0", 5'h08, 0);
    endtask

    task automatic t_arrival();
        wr(5'h01, 32'h1FF);
        arrive(8'h45, 1'b1, 1'b1);
        chk_rd("R1 irr w2", 5'h1A, 32'h20);
        chk_rd("R1 tmr w2 level", 5'h12, 32'h20);
        chk("R4 int_out ppr zero", int_out, 1);
        arrive(8'h45, 1'b0, 1'b0);
        chk_rd("R1 tmr w2 edge", 5'h12, 0);
    endtask

    task automatic t_ack();
        do_ack("R6 ack vector", 8'h45);
        chk_rd("R6 isr w2", 5'h0A, 32'h20);
        chk_rd("R6 irr w2", 5'h1A, 0);
        chk_rd("R3 ppr from isr", 5'h02, 32'h40);
        arrive(8'h43, 1'b0, 1'b1);
        chk("R4 same class blocked", int_out, 0);
        do_ack("R7 blocked ack", 8'hFF);
        chk_rd("R7 irr kept", 5'h1A, 32'h08);
        arrive(8'h52, 1'b0, 1'b1);
        chk("R4 higher class", int_out, 1);
        do_ack("R6 ack 0x52", 8'h52);
        chk_rd("R6 isr two bits", 5'h0A, 32'h0004_0020);
        chk_rd("R3 ppr 0x50", 5'h02, 32'h50);
    endtask

    task automatic t_tpr();
        cpu_tpr_we = 1'b1; cpu_tpr_nib = 4'h6;
        tick();
        cpu_tpr_we = 1'b0;
        chk_rd("R5 cpu tpr", 5'h00, 32'h60);
        chk_rd("R3 ppr=tpr", 5'h02, 32'h60);
        chk("R4 tpr blocks", int_out, 0);
        wr(5'h00, 32'h3A);
        chk_rd("R5 reg tpr", 5'h00, 32'h3A);
        chk_rd("R3 ppr=isr class", 5'h02, 32'h50);
    endtask

    task automatic t_eoi();
        do_eoi(1'b0, 8'h00);
        chk_rd("R8 isr after eoi", 5'h0A, 32'h20);
        chk_rd("R3 ppr 0x40", 5'h02, 32'h40);
        arrive(8'h70, 1'b1, 1'b1);
        chk("R4 class 7", int_out, 1);
        do_ack("R6 ack 0x70", 8'h70);
        do_eoi(1'b1, 8'h70);
        chk_rd("R8 isr w3 clear", 5'h0B, 0);
        wr(5'h01, 32'hFFFF_FFFF);
        chk_rd("R10 svr mask", 5'h01, 32'h11FF);
        arrive(8'h71, 1'b1, 1'b1);
        do_ack("R6 ack 0x71", 8'h71);
        do_eoi(1'b0, 8'h00);
        wr(5'h01, 32'h1FF);
        do_eoi(1'b0, 8'h00);
        chk_rd("R8 isr empty", 5'h0A, 0);
        do_eoi(1'b0, 8'h00);
        chk_rd("R8 empty eoi", 5'h0A, 0);
        chk_rd("R3 ppr=tpr", 5'h02, 32'h3A);
    endtask

    task automatic t_disable();
        chk("R4 class4 over 3", int_out, 1);
        wr(5'h01, 32'h0FF);
        chk("R10 disabled", int_out, 0);
        do_ack("R7 disabled ack", 8'hFF);
        chk_rd("R7 irr kept", 5'h1A, 32'h08);
        wr(5'h01, 32'h1FF);
    endtask

    task automatic t_class0();
        cpu_tpr_we = 1'b1; cpu_tpr_nib = 4'h0;
        tick();
        cpu_tpr_we = 1'b0;
        do_ack("R6 ack 0x43", 8'h43);
        do_eoi(1'b0, 8'h00);
        arrive(8'h05, 1'b0, 1'b1);
        chk("R4 class0 with ppr 0", int_out, 1);
        do_ack("R6 ack 0x05", 8'h05);
        chk_rd("R6 isr w0", 5'h08, 32'h20);
        do_eoi(1'b0, 8'h00);
    endtask

    task automatic t_windows();
        wr(5'h18, 32'h0000_FFFF);
        chk_rd("R12 window write ignored", 5'h18, 0);
        chk_rd("R12 unmapped", 5'h05, 0);
        arrive(8'hF0, 1'b1, 1'b1);
        chk_rd("R12 irr w7", 5'h1F, 32'h0001_0000);
        chk_rd("R12 tmr w7", 5'h17, 32'h0001_0000);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk_rd("R11 irr cleared", 5'h1F, 0);
        chk("R11 int_out", int_out, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        #1;
        t_reset();
        t_arrival();
        t_ack();
        t_tpr();
        t_eoi();
        t_disable();
        t_class0();
        t_windows();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule